// File: doc/BRIEF.md
# I2C master transfer sequencer

This block is the command and buffer layer of an I2C master. Software programs it through a word-addressed register port, and it passes byte-level commands (START, STOP, write byte, read byte) to a separate bit-level engine that owns SCL and SDA. The block holds a 32-byte transmit buffer and a 32-byte receive buffer. It steps through a transaction in one of three modes, records each event in a write-one-to-clear pending register, and drives one interrupt line.

A transaction begins with a START request. After the START completes, the sequencer parks until software writes a count register. Writing the transmit count sends that many bytes from the transmit buffer. Writing the receive count reads a chunk of that many bytes into the receive buffer. In register-transmit mode, the first receive-count write comes before the read and sends the following: the valid slave-address bytes, the valid register-address bytes, a repeated START, and the slave address with the read bit set. Only then does the read begin. Further receive-count writes continue reading on the bus without a new START. Writing zero to the control word returns the sequencer to idle, so the next START acts as a repeated start.

Register word indices: 0 control, 1 slave-address word, 2 register-address word, 3 transmit count, 4 receive count, 5 interrupt enable, 6 interrupt pending. The transmit buffer sits at words 16..23 and the receive buffer at words 32..39.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset every register, both counts and the pending word read 0, irq is low, and no engine command is requested.
- R2: When control bit 0 (enable) and bit 3 (START request) are set in idle, exactly one START command (op 0) is issued, and pending bit 4 is set when it completes.
- R3: In transmit mode (control bits 2:1 = 0), a write to the transmit count sends that many write commands (op 2). The bytes come from the transmit buffer, four per word, little-endian. Pending bit 0 is set per byte and bit 2 after the last byte.
- R4: In register-transmit mode (bits 2:1 = 1), the first receive-count write first sends the bytes in this order: slave-address bytes x = 0..2 whose valid bit 24+x is set, then the register-address bytes with the same rule, then a START, then slave-address byte 0 OR 1. It then reads.
- R5: In register-transmit mode with no valid register-address byte, the restart and the re-addressing are skipped and the read follows the slave-address bytes directly.
- R6: A receive chunk issues receive-count read commands (op 3) and stores the bytes little-endian from receive byte 0. Pending bit 3 is set when the chunk ends. The final read of the chunk requests NACK exactly when control bit 5 is set.
- R7: A later receive-count write in receive mode (bits 2:1 = 2) continues with read commands and no START. Buffer bytes beyond the new chunk keep their values.
- R8: Writing 1 to a pending bit clears it, and writing 0x7F clears all bits. A bit that is being set in the same cycle stays set.
- R9: irq is high exactly when some pending bit and its enable bit are both 1.
- R10: A NACK on any write sets pending bit 6. If control bit 6 (abort) is set, no further command is issued until a STOP request. If bit 6 is clear, the burst continues.
- R11: A STOP request (control bit 4), made while parked or halted, issues one STOP command (op 1), sets pending bit 5 on completion and returns to idle.
- R12: Writing 0 to the control word returns the sequencer to idle and forgets that the address phase was sent. The next START request issues a plain START, and the next register-transmit read sends its address bytes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word index of the write |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 6 | Word index to read |
| reg_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| cmd_valid | output | 1 | Command request to the bit engine, held until eng_done |
| cmd_op | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| cmd_wdata | output | 8 | Byte to write |
| cmd_rd_nack | output | 1 | Answer the read byte with NACK |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_nack | input | 1 | Write byte was not acknowledged (valid with eng_done) |
| eng_rdata | input | 8 | Byte received (valid with eng_done) |

## Verification
A wrong internal state shows at the ports as a command that is wrong or out of order at the engine interface. The scoreboard catches it at the acceptance edge of the first bad command: a byte from the wrong buffer lane, a skipped valid address byte, a START that should not be there, or a command issued after an abort. A state that forgets the address phase or misplaces a received byte shows up a few cycles later. It appears in the pending word, in irq, or in the receive-buffer word read back after the chunk.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_PARK, ST_TX, ST_SADR, ST_RADR,
        ST_RSTRT, ST_RDADR, ST_RX, ST_HALT, ST_STOP
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } seq_op_e;

    // control word fields
    localparam int C_EN      = 0;
    localparam int C_START   = 3;
    localparam int C_STOP    = 4;
    localparam int C_LASTNAK = 5;
    localparam int C_ABORT   = 6;
    localparam logic [1:0] MODE_TX    = 2'd0;
    localparam logic [1:0] MODE_REGTX = 2'd1;

    // event bits, shared by enable and pending
    localparam int EV_BTX   = 0;
    localparam int EV_BRX   = 1;
    localparam int EV_MTX   = 2;
    localparam int EV_MRX   = 3;
    localparam int EV_START = 4;
    localparam int EV_STOP  = 5;
    localparam int EV_NACK  = 6;
    localparam int EV_W     = 7;

    // register word indices
    localparam int A_CTRL  = 0;
    localparam int A_SADR  = 1;
    localparam int A_RADR  = 2;
    localparam int A_TXCNT = 3;
    localparam int A_RXCNT = 4;
    localparam int A_IEN   = 5;
    localparam int A_IPD   = 6;
    localparam int A_TXBUF = 16;
    localparam int A_RXBUF = 32;

endpackage

// File: rtl/i2c_seq_buf.sv
module i2c_seq_buf #(
    parameter int BYTES = 32,
    localparam int WORDS  = BYTES / 4,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int BIDX_W = $clog2(BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_we,
    input  logic [WIDX_W-1:0]    word_idx,
    input  logic [31:0]          word_data,
    input  logic                 byte_we,
    input  logic [BIDX_W-1:0]    byte_idx,
    input  logic [7:0]           byte_data,
    output logic [8*BYTES-1:0]   image
);
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (byte_we && byte_idx == BIDX_W'(b)) begin
                lane_q <= byte_data;
            end else if (word_we && word_idx == WIDX_W'(b / 4)) begin
                lane_q <= word_data[8*(b%4) +: 8];
            end
        end
        assign image[8*b +: 8] = lane_q;
    end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
    import i2c_seq_pkg::*;
#(
    parameter int BUF_BYTES = 32,
    parameter int ADDR_W    = 6,
    localparam int WORDS    = BUF_BYTES / 4,
    localparam int WIDX_W   = $clog2(WORDS),
    localparam int BIDX_W   = $clog2(BUF_BYTES),
    localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [7:0]        cmd_wdata,
    output logic              cmd_rd_nack,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rdata
);
    localparam int TXB_SEL = A_TXBUF >> WIDX_W;
    localparam int RXB_SEL = A_RXBUF >> WIDX_W;

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] idx;
        logic [1:0]       sub;
        logic             addr_done;
        logic [6:0]       ctrl;
        logic [31:0]      saddr;
        logic [31:0]      raddr;
        logic [CNT_W-1:0] txcnt;
        logic [CNT_W-1:0] rxcnt;
        logic [EV_W-1:0]  ien;
        logic [EV_W-1:0]  ipd;
    } regs_t;

    regs_t q, d;
    logic [8*BUF_BYTES-1:0] tx_image, rx_image;
    logic [EV_W-1:0]        ev_set, ev_clr;
    logic                   rx_we, tx_buf_we, tx_cnt_wr, rx_cnt_wr;
    logic [CNT_W-1:0]       cnt_wval;
    logic [7:0]             tx_byte;

    assign tx_buf_we = reg_we && (reg_addr[ADDR_W-1:WIDX_W] == (ADDR_W-WIDX_W)'(TXB_SEL));
    assign tx_cnt_wr = reg_we && reg_addr == ADDR_W'(A_TXCNT);
    assign rx_cnt_wr = reg_we && reg_addr == ADDR_W'(A_RXCNT);
    assign cnt_wval  = (reg_wdata > 32'(BUF_BYTES)) ? CNT_W'(BUF_BYTES) : reg_wdata[CNT_W-1:0];
    assign tx_byte   = tx_image[8*q.idx[BIDX_W-1:0] +: 8];

    i2c_seq_buf #(.BYTES(BUF_BYTES)) u_txbuf (
        .clk(clk), .rst_n(rst_n),
        .word_we(tx_buf_we), .word_idx(reg_addr[WIDX_W-1:0]), .word_data(reg_wdata),
        .byte_we(1'b0), .byte_idx('0), .byte_data(8'h00),
        .image(tx_image)
    );

    i2c_seq_buf #(.BYTES(BUF_BYTES)) u_rxbuf (
        .clk(clk), .rst_n(rst_n),
        .word_we(1'b0), .word_idx('0), .word_data(32'h0),
        .byte_we(rx_we), .byte_idx(q.idx[BIDX_W-1:0]), .byte_data(eng_rdata),
        .image(rx_image)
    );

    always_comb begin
        d           = q;
        ev_set      = '0;
        ev_clr      = '0;
        rx_we       = 1'b0;
        cmd_valid   = 1'b0;
        cmd_op      = OP_START;
        cmd_wdata   = 8'h00;
        cmd_rd_nack = 1'b0;

        if (reg_we) begin
            case (reg_addr)
                ADDR_W'(A_CTRL):  d.ctrl  = reg_wdata[6:0];
                ADDR_W'(A_SADR):  d.saddr = reg_wdata;
                ADDR_W'(A_RADR):  d.raddr = reg_wdata;
                ADDR_W'(A_TXCNT): d.txcnt = cnt_wval;
                ADDR_W'(A_RXCNT): d.rxcnt = cnt_wval;
                ADDR_W'(A_IEN):   d.ien   = reg_wdata[EV_W-1:0];
                ADDR_W'(A_IPD):   ev_clr  = reg_wdata[EV_W-1:0];
                default: ;
            endcase
        end

        case (q.state)
            ST_IDLE: if (q.ctrl[C_EN] && q.ctrl[C_START]) d.state = ST_START;
            ST_START, ST_RSTRT: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_START;
                if (eng_done) begin
                    ev_set[EV_START] = (q.state == ST_START);
                    d.state = (q.state == ST_START) ? ST_PARK : ST_RDADR;
                end
            end
            ST_PARK: begin
                if (q.ctrl[C_STOP]) begin
                    d.state = ST_STOP;
                end else if (tx_cnt_wr) begin
                    d.idx   = '0;
                    d.state = ST_TX;
                end else if (rx_cnt_wr) begin
                    d.idx   = '0;
                    d.sub   = '0;
                    d.state = (q.ctrl[2:1] == MODE_REGTX && !q.addr_done) ? ST_SADR : ST_RX;
                end
            end
            ST_TX, ST_SADR, ST_RADR, ST_RDADR: begin
                if (q.state == ST_TX && q.idx == q.txcnt) begin
                    ev_set[EV_MTX] = 1'b1;
                    d.state = ST_PARK;
                end else if (q.state == ST_SADR && (q.sub == 2'd3)) begin
                    d.sub   = '0;
                    d.state = ST_RADR;
                end else if (q.state == ST_RADR && (q.sub == 2'd3)) begin
                    d.addr_done = ~|q.raddr[26:24];
                    d.state     = (|q.raddr[26:24]) ? ST_RSTRT : ST_RX;
                end else if (q.state == ST_SADR && !q.saddr[24 + int'(q.sub)]) begin
                    d.sub = q.sub + 2'd1;
                end else if (q.state == ST_RADR && !q.raddr[24 + int'(q.sub)]) begin
                    d.sub = q.sub + 2'd1;
                end else begin
                    cmd_valid = 1'b1;
                    cmd_op    = OP_WRITE;
                    case (q.state)
                        ST_TX:   cmd_wdata = tx_byte;
                        ST_SADR: cmd_wdata = q.saddr[8*q.sub +: 8];
                        ST_RADR: cmd_wdata = q.raddr[8*q.sub +: 8];
                        default: cmd_wdata = q.saddr[7:0] | 8'h01;
                    endcase
                    if (eng_done) begin
                        ev_set[EV_BTX]  = 1'b1;
                        ev_set[EV_NACK] = eng_nack;
                        d.idx = (q.state == ST_TX) ? q.idx + CNT_W'(1) : q.idx;
                        d.sub = q.sub + 2'd1;
                        if (q.state == ST_RDADR) begin
                            d.addr_done = 1'b1;
                            d.state     = ST_RX;
                        end
                        if (eng_nack && q.ctrl[C_ABORT]) d.state = ST_HALT;
                    end
                end
            end
            ST_RX: begin
                if (q.idx == q.rxcnt) begin
                    ev_set[EV_MRX] = 1'b1;
                    d.state = ST_PARK;
                end else begin
                    cmd_valid   = 1'b1;
                    cmd_op      = OP_READ;
                    cmd_rd_nack = q.ctrl[C_LASTNAK] && (q.idx + CNT_W'(1) == q.rxcnt);
                    if (eng_done) begin
                        rx_we          = 1'b1;
                        ev_set[EV_BRX] = 1'b1;
                        d.idx          = q.idx + CNT_W'(1);
                    end
                end
            end
            ST_HALT: if (q.ctrl[C_STOP]) d.state = ST_STOP;
            ST_STOP: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_STOP;
                if (eng_done) begin
                    ev_set[EV_STOP] = 1'b1;
                    d.addr_done     = 1'b0;
                    d.state         = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (!q.ctrl[C_EN]) begin
            d.state     = ST_IDLE;
            d.addr_done = 1'b0;
        end
        d.ipd = (q.ipd & ~ev_clr) | ev_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = 32'h0;
        if (reg_raddr[ADDR_W-1:WIDX_W] == (ADDR_W-WIDX_W)'(TXB_SEL))
            reg_rdata = tx_image[32*reg_raddr[WIDX_W-1:0] +: 32];
        else if (reg_raddr[ADDR_W-1:WIDX_W] == (ADDR_W-WIDX_W)'(RXB_SEL))
            reg_rdata = rx_image[32*reg_raddr[WIDX_W-1:0] +: 32];
        else begin
            case (reg_raddr)
                ADDR_W'(A_CTRL):  reg_rdata = 32'(q.ctrl);
                ADDR_W'(A_SADR):  reg_rdata = q.saddr;
                ADDR_W'(A_RADR):  reg_rdata = q.raddr;
                ADDR_W'(A_TXCNT): reg_rdata = 32'(q.txcnt);
                ADDR_W'(A_RXCNT): reg_rdata = 32'(q.rxcnt);
                ADDR_W'(A_IEN):   reg_rdata = 32'(q.ien);
                ADDR_W'(A_IPD):   reg_rdata = 32'(q.ipd);
                default:          reg_rdata = 32'h0;
            endcase
        end
    end

    assign irq = |(q.ipd & q.ien);

    // aliases observed by the bound checker
    seq_state_e      cur_state;
    logic [EV_W-1:0] ipd_now;
    logic            abort_on;
    assign cur_state = q.state;
    assign ipd_now   = q.ipd;
    assign abort_on  = q.ctrl[C_ABORT];
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk
    import i2c_seq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input seq_state_e        cur_state,
    input logic [EV_W-1:0]   ipd_now,
    input logic              abort_on,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              cmd_rd_nack,
    input logic              eng_done,
    input logic              eng_nack,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata
);
    // R1: idle never requests a command
    a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state == ST_IDLE |-> !cmd_valid);

    // R2: a requested command holds its opcode until the engine completes it
    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !eng_done && !reg_we) |=> (cmd_valid && $stable(cmd_op)));

    // R6: a NACK request only ever accompanies a read
    a_r6_nack_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_rd_nack) |-> cmd_op == 2'(OP_READ));

    // R8: clearing all pending bits while no event can fire empties the word
    a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(A_IPD) && reg_wdata[EV_W-1:0] == 7'h7F &&
         (cur_state == ST_IDLE || cur_state == ST_PARK || cur_state == ST_HALT))
        |=> ipd_now == '0);

    // R10: a refused data byte with abort set halts and flags the NACK
    a_r10_abort_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_nack && cur_state == ST_TX && abort_on)
        |=> (cur_state == ST_HALT && ipd_now[EV_NACK]));

    // R10: a halted sequencer stays quiet on the engine interface
    a_r10_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state == ST_HALT |-> !cmd_valid);

    // R11: a completed STOP returns to idle and flags the event
    a_r11_stop_done: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && cur_state == ST_STOP) |=> (cur_state == ST_IDLE && ipd_now[EV_STOP]));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cur_state(cur_state), .ipd_now(ipd_now),
    .abort_on(abort_on), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_rd_nack(cmd_rd_nack), .eng_done(eng_done), .eng_nack(eng_nack),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_START = 2'd0, K_STOP = 2'd1, K_WR = 2'd2, K_RD = 2'd3;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0, reg_raddr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq, cmd_valid, cmd_rd_nack;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_wdata;
    logic        eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0]  eng_rdata = '0;

    int n_cmp = 0, n_bad = 0;
    int wr_ord = 0, rd_ord = 0, nack_at = -1;
    logic       eng_busy = 1'b0;
    logic [1:0] eng_cnt = '0, eng_op = '0;
    logic [10:0] expq[$];

    i2c_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq(irq), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .cmd_rd_nack(cmd_rd_nack), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_rdata(eng_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic push(input logic [1:0] op, input logic nk, input logic [7:0] b);
        expq.push_back({op, nk, b});
    endtask

    // bit-engine model and monitor side of the scoreboard
    always @(posedge clk) begin
        eng_done <= 1'b0;
        eng_nack <= 1'b0;
        if (eng_busy) begin
            if (eng_cnt == 0) begin
                eng_done <= 1'b1;
                eng_busy <= 1'b0;
                if (eng_op == K_WR) begin
                    eng_nack <= (wr_ord == nack_at);
                    wr_ord   <= wr_ord + 1;
                end
                if (eng_op == K_RD) begin
                    eng_rdata <= 8'hC0 + 8'(rd_ord);
                    rd_ord    <= rd_ord + 1;
                end
            end else begin
                eng_cnt <= eng_cnt - 2'd1;
            end
        end else if (rst_n && cmd_valid && !eng_done) begin
            logic [10:0] seen;
            eng_busy <= 1'b1;
            eng_cnt  <= 2'd1;
            eng_op   <= cmd_op;
            seen = {cmd_op, (cmd_op == K_RD) ? cmd_rd_nack : 1'b0,
                    (cmd_op == K_WR) ? cmd_wdata : 8'h00};
            n_cmp++;
            if (expq.size() == 0) begin
                n_bad++;
                $display("FAIL command order: got %h expected none", seen);
            end else begin
                logic [10:0] want;
                want = expq.pop_front();
                if (seen !== want) begin
                    n_bad++;
                    $display("FAIL command order: got %h expected %h", seen, want);
                end
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_raddr = 6'(a);
        #1 v = reg_rdata;
    endtask

    task automatic wait_ev(input int bitpos, input string req);
        logic [31:0] v;
        for (int i = 0; i < 300; i++) begin
            rd(6, v);
            if (v[bitpos]) return;
        end
        check(req, 32'h0, 32'h1 << bitpos);
    endtask

    task automatic drained(input string req);
        check(req, 32'(expq.size()), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, v); check("R1 ctrl", v, 0);
        rd(6, v); check("R1 pending", v, 0);
        rd(3, v); check("R1 txcnt", v, 0);
        check("R1 irq", 32'(irq), 0);

        // R2 / R3 / R9 / R8 / R11 plain transmit
        wr(5, 32'h10);
        push(K_START, 0, 0);
        wr(0, 32'h49);
        wait_ev(4, "R2 start event");
        check("R9 irq with enabled start", 32'(irq), 1);
        wr(6, 32'h10);
        rd(6, v); check("R8 start cleared", v, 0);
        check("R9 irq after clear", 32'(irq), 0);
        wr(0, 32'h41);
        wr(16, 32'h33221150);
        wr(17, 32'h00000044);
        push(K_WR, 0, 8'h50); push(K_WR, 0, 8'h11); push(K_WR, 0, 8'h22);
        push(K_WR, 0, 8'h33); push(K_WR, 0, 8'h44);
        wr(3, 5);
        wait_ev(2, "R3 transmit finished");
        rd(6, v); check("R3 pending after burst", v, 32'h05);
        drained("R3 all bytes sent");
        push(K_STOP, 0, 0);
        wr(0, 32'h51);
        wait_ev(5, "R11 stop event");
        wr(6, 32'h7F);
        rd(6, v); check("R8 clear all", v, 0);

        // R4 / R6 register transmit then read
        wr(0, 0);
        wr(1, 32'h010000A0);
        wr(2, 32'h03003412);
        push(K_START, 0, 0);
        wr(0, 32'h6B);
        wait_ev(4, "R2 start event");
        wr(6, 32'h7F);
        wr(0, 32'h63);
        push(K_WR, 0, 8'hA0); push(K_WR, 0, 8'h12); push(K_WR, 0, 8'h34);
        push(K_START, 0, 0); push(K_WR, 0, 8'hA1);
        push(K_RD, 0, 0); push(K_RD, 0, 0); push(K_RD, 1, 0);
        wr(4, 3);
        wait_ev(3, "R6 chunk finished");
        rd(32, v); check("R6 receive word", v, 32'h00C2C1C0);
        rd(6, v); check("R4 pending after address phase", v, 32'h0B);
        drained("R4 address phase order");

        // R7 continuation without START, last byte acked
        wr(6, 32'h7F);
        wr(0, 32'h45);
        push(K_RD, 0, 0); push(K_RD, 0, 0);
        wr(4, 2);
        wait_ev(3, "R7 chunk finished");
        rd(32, v); check("R7 continued word", v, 32'h00C2C4C3);
        drained("R7 no restart");

        // R12 / R5 reset by zero control, read with skipped bytes
        wr(0, 0);
        wr(6, 32'h7F);
        wr(1, 32'h057766A1);
        wr(2, 32'h0);
        push(K_START, 0, 0);
        wr(0, 32'h6B);
        wait_ev(4, "R12 fresh start");
        wr(6, 32'h7F);
        wr(0, 32'h63);
        push(K_WR, 0, 8'hA1); push(K_WR, 0, 8'h77); push(K_RD, 1, 0);
        wr(4, 1);
        wait_ev(3, "R5 read finished");
        rd(32, v); check("R5 received byte", v, 32'h00C2C4C5);
        drained("R5 no restart without register bytes");
        push(K_STOP, 0, 0);
        wr(0, 32'h73);
        wait_ev(5, "R11 stop event");

        // R10 abort on NACK
        wr(0, 0);
        wr(6, 32'h7F);
        wr(5, 32'h40);
        push(K_START, 0, 0);
        wr(0, 32'h49);
        wait_ev(4, "R2 start event");
        wr(6, 32'h10);
        wr(0, 32'h41);
        wr(16, 32'h030201A0);
        nack_at = wr_ord + 1;
        push(K_WR, 0, 8'hA0); push(K_WR, 0, 8'h01);
        wr(3, 4);
        wait_ev(6, "R10 nack event");
        repeat (20) @(negedge clk);
        rd(6, v); check("R10 halted pending", v, 32'h41);
        check("R9 irq on nack", 32'(irq), 1);
        drained("R10 no command after abort");
        push(K_STOP, 0, 0);
        wr(0, 32'h51);
        wait_ev(5, "R11 stop from halt");

        // R10 NACK without abort continues
        wr(0, 0);
        wr(6, 32'h7F);
        push(K_START, 0, 0);
        wr(0, 32'h09);
        wait_ev(4, "R2 start event");
        wr(6, 32'h10);
        wr(0, 32'h01);
        nack_at = wr_ord + 1;
        push(K_WR, 0, 8'hA0); push(K_WR, 0, 8'h01);
        push(K_WR, 0, 8'h02); push(K_WR, 0, 8'h03);
        wr(3, 4);
        wait_ev(2, "R10 burst completes");
        rd(6, v); check("R10 nack kept going", v & 32'h44, 32'h44);
        wr(5, 0);
        @(negedge clk);
        check("R9 irq masked", 32'(irq), 0);
        drained("R10 all bytes sent");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule